// File: doc/BRIEF.md
# Sequential Signed 32/16 Divider

This block divides a signed 32-bit dividend by a signed 16-bit divisor over a series of clock cycles. The divisor is taken from the low half of a full-width source operand, and the upper half of that operand is ignored. When the division succeeds, the block returns one packed word with the 16-bit remainder in the upper half and the 16-bit quotient in the lower half. It also raises a write-enable pulse so that the surrounding datapath can overwrite the destination.

The block works on magnitudes. It runs one restoring subtract step per cycle, 16 steps in all, and then applies the signs. The quotient truncates toward zero and the remainder takes the sign of the dividend. Two outcomes end a request at once, without the step sequence: a zero divisor, and a magnitude quotient of 2^16 or more. A quotient that does not fit the signed 16-bit range sets the overflow flag. A zero divisor raises a separate divide-by-zero output. In both of these cases the write-enable stays low and the result output keeps its previous value. A start request is accepted only while the block is idle.

Top module: `sdiv32x16`

## Requirements
- R1: The dividend is the full 32-bit `dividend` input. The divisor is only bits 15:0 of `divisor`, so bits 31:16 of `divisor` have no effect on the outcome.
- R2: On success, `result[15:0]` is the signed quotient truncated toward zero and `result[31:16]` is the signed remainder, which carries the sign of the dividend (quotient × divisor + remainder = dividend).
- R3: A quotient outside -32768..32767 sets `flag_v` to 1 with `done`. `wr_en` stays 0 and `result` keeps its previous value.
- R4: A divisor whose low 16 bits are zero pulses `div_zero` together with `done`, with `flag_v` = 0. `wr_en` stays 0 and `result` keeps its previous value.
- R5: At `done` after a successful division, `flag_n` equals quotient bit 15 and `flag_z` is 1 only when the 16-bit quotient is zero. After an overflow or a zero divisor, `flag_n` and `flag_z` are both 0. `flag_c` is 0 at every `done`.
- R6: A start accepted on a rising edge normally brings `done` high in the cycle after the 17th rising edge from that one, with `busy` high in between. A zero divisor, or a quotient magnitude of 2^16 or more, brings `done` high in the cycle right after the accepting edge.
- R7: `done` is high for one cycle per accepted request. `wr_en` is high only in the `done` cycle of a successful division.
- R8: `start` while `busy` is high is ignored: the running operation keeps its operands and no additional `done` follows.
- R9: A synchronous active-high reset clears `busy`, `done`, `wr_en`, `div_zero`, all four flags and `result` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a division (honoured only while idle) |
| dividend | input | 32 | Signed dividend |
| divisor | input | 32 | Source operand; low 16 bits are the signed divisor |
| busy | output | 1 | Step sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Packed remainder (31:16) and quotient (15:0) |
| wr_en | output | 1 | Destination write enable, pulses on successful completion |
| flag_v | output | 1 | Quotient overflow |
| flag_n | output | 1 | Quotient negative |
| flag_z | output | 1 | Quotient zero |
| flag_c | output | 1 | Carry, always cleared |
| div_zero | output | 1 | Divide-by-zero indication, pulses with done |

## Verification
The bench builds the block with its default width of 32, which sets the divisor and quotient width to 16 and the step count to 16. At this width the full-scale corners can be reached directly: the most negative dividend, a quotient of exactly -32768 next to +32768, which overflows only through the sign, and a dividend just under 32767 squared. The same width also places the early-exit boundary on the comparison between the dividend's upper half and the divisor. The latency of each request is counted, so the short and the full path are told apart, as well as the packed values and flags.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } div_state_e;

    typedef struct packed {
        logic v;
        logic n;
        logic z;
        logic c;
    } div_flags_t;

    // Flags for an operation that ends without a written result.
    function automatic div_flags_t flags_abort(input logic ovf);
        div_flags_t f;
        f.v = ovf;
        f.n = 1'b0;
        f.z = 1'b0;
        f.c = 1'b0;
        return f;
    endfunction

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
    parameter int DATA_W = 32,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic [DATA_W-1:0] dividend,
    input  logic [HALF_W-1:0] divisor_lo,
    output logic [DATA_W-1:0] dvd_mag,
    output logic [HALF_W-1:0] dvs_mag,
    output logic              neg_quo,
    output logic              neg_rem,
    output logic              dvs_zero,
    output logic              too_big
);
    logic dvd_neg;
    logic dvs_neg;

    always_comb begin
        dvd_neg  = dividend[DATA_W-1];
        dvs_neg  = divisor_lo[HALF_W-1];
        dvd_mag  = dvd_neg ? (~dividend + 1'b1) : dividend;
        dvs_mag  = dvs_neg ? (~divisor_lo + 1'b1) : divisor_lo;
        neg_quo  = dvd_neg ^ dvs_neg;
        neg_rem  = dvd_neg;
        dvs_zero = (divisor_lo == '0);
        // Upper half not below divisor means magnitude quotient >= 2^HALF_W.
        too_big  = (dvd_mag[DATA_W-1:HALF_W] >= dvs_mag);
    end
endmodule

// File: rtl/div_step.sv
module div_step #(
    parameter int HALF_W = 16
) (
    input  logic [HALF_W-1:0] rem_in,
    input  logic [HALF_W-1:0] quo_in,
    input  logic [HALF_W-1:0] dvs_mag,
    output logic [HALF_W-1:0] rem_out,
    output logic [HALF_W-1:0] quo_out
);
    logic [HALF_W:0] trial;
    logic [HALF_W:0] diff;
    logic            fits;

    always_comb begin
        trial   = {rem_in, quo_in[HALF_W-1]};
        diff    = trial - {1'b0, dvs_mag};
        fits    = (trial >= {1'b0, dvs_mag});
        rem_out = fits ? diff[HALF_W-1:0] : trial[HALF_W-1:0];
        quo_out = {quo_in[HALF_W-2:0], fits};
    end
endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix #(
    parameter int HALF_W = 16
) (
    input  logic [HALF_W-1:0] quo_mag,
    input  logic [HALF_W-1:0] rem_mag,
    input  logic              neg_quo,
    input  logic              neg_rem,
    output logic [HALF_W-1:0] quo_s,
    output logic [HALF_W-1:0] rem_s,
    output logic              ovf
);
    always_comb begin
        quo_s = neg_quo ? (~quo_mag + 1'b1) : quo_mag;
        rem_s = neg_rem ? (~rem_mag + 1'b1) : rem_mag;
        if (neg_quo)
            ovf = quo_mag[HALF_W-1] && (|quo_mag[HALF_W-2:0]);
        else
            ovf = quo_mag[HALF_W-1];
    end
endmodule

// File: rtl/sdiv32x16.sv
module sdiv32x16 #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] dividend,
    input  logic [DATA_W-1:0] divisor,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic              flag_v,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              div_zero
);
    import div_pkg::*;

    localparam int HALF_W = DATA_W / 2;
    localparam int CNT_W  = $clog2(HALF_W);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(HALF_W - 1);

    div_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [HALF_W-1:0] rem_q, quo_q, dvs_q;
    logic              negq_q, negr_q;
    logic [DATA_W-1:0] res_q;
    div_flags_t        flags_q;
    logic              done_q, wr_q, dz_q;

    logic [DATA_W-1:0] dvd_mag;
    logic [HALF_W-1:0] dvs_mag;
    logic              neg_quo, neg_rem, dvs_zero, too_big;
    logic [HALF_W-1:0] rem_n, quo_n, quo_s, rem_s;
    logic              fix_ovf;

    div_operand_prep #(.DATA_W(DATA_W)) i_prep (
        .dividend   (dividend),
        .divisor_lo (divisor[HALF_W-1:0]),
        .dvd_mag    (dvd_mag),
        .dvs_mag    (dvs_mag),
        .neg_quo    (neg_quo),
        .neg_rem    (neg_rem),
        .dvs_zero   (dvs_zero),
        .too_big    (too_big)
    );

    div_step #(.HALF_W(HALF_W)) i_step (
        .rem_in  (rem_q),
        .quo_in  (quo_q),
        .dvs_mag (dvs_q),
        .rem_out (rem_n),
        .quo_out (quo_n)
    );

    div_sign_fix #(.HALF_W(HALF_W)) i_fix (
        .quo_mag (quo_n),
        .rem_mag (rem_n),
        .neg_quo (negq_q),
        .neg_rem (negr_q),
        .quo_s   (quo_s),
        .rem_s   (rem_s),
        .ovf     (fix_ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            rem_q   <= '0;
            quo_q   <= '0;
            dvs_q   <= '0;
            negq_q  <= 1'b0;
            negr_q  <= 1'b0;
            res_q   <= '0;
            flags_q <= '0;
            done_q  <= 1'b0;
            wr_q    <= 1'b0;
            dz_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            wr_q   <= 1'b0;
            dz_q   <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (dvs_zero) begin
                            done_q  <= 1'b1;
                            dz_q    <= 1'b1;
                            flags_q <= flags_abort(1'b0);
                        end else if (too_big) begin
                            done_q  <= 1'b1;
                            flags_q <= flags_abort(1'b1);
                        end else begin
                            rem_q   <= dvd_mag[DATA_W-1:HALF_W];
                            quo_q   <= dvd_mag[HALF_W-1:0];
                            dvs_q   <= dvs_mag;
                            negq_q  <= neg_quo;
                            negr_q  <= neg_rem;
                            cnt_q   <= '0;
                            state_q <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    rem_q <= rem_n;
                    quo_q <= quo_n;
                    if (cnt_q == LAST_STEP) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        if (fix_ovf) begin
                            flags_q <= flags_abort(1'b1);
                        end else begin
                            res_q     <= {rem_s, quo_s};
                            wr_q      <= 1'b1;
                            flags_q.v <= 1'b0;
                            flags_q.n <= quo_s[HALF_W-1];
                            flags_q.z <= (quo_s == '0);
                            flags_q.c <= 1'b0;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state_q == ST_RUN);
    assign done     = done_q;
    assign result   = res_q;
    assign wr_en    = wr_q;
    assign flag_v   = flags_q.v;
    assign flag_n   = flags_q.n;
    assign flag_z   = flags_q.z;
    assign flag_c   = flags_q.c;
    assign div_zero = dz_q;
endmodule

// File: rtl/sdiv32x16_chk.sv
module sdiv32x16_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] result,
    input logic              wr_en,
    input logic              flag_v,
    input logic              flag_n,
    input logic              flag_z,
    input logic              flag_c,
    input logic              div_zero
);
    AST_WE_ONLY_ON_SUCCESS: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (done && !flag_v && !div_zero));                          // R7
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> $stable(result));                                         // R3
    AST_DZ_NOT_OVF: assert property (@(posedge clk) disable iff (rst)
        div_zero |-> (done && !flag_v && !wr_en));                           // R4
    AST_ABORT_NZ_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (done && (flag_v || div_zero)) |-> (!flag_n && !flag_z));            // R5
    AST_CARRY_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> !flag_c);                                                   // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !done);                                         // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);                                                     // R6
    AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> !div_zero);                                      // R8
endmodule

bind sdiv32x16 sdiv32x16_chk #(.DATA_W(DATA_W)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .result   (result),
    .wr_en    (wr_en),
    .flag_v   (flag_v),
    .flag_n   (flag_n),
    .flag_z   (flag_z),
    .flag_c   (flag_c),
    .div_zero (div_zero)
);

// File: tb/test_sdiv32x16.sv
module test_sdiv32x16;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] dividend = '0;
    logic [31:0] divisor = '0;
    logic        busy, done, wr_en, flag_v, flag_n, flag_z, flag_c, div_zero;
    logic [31:0] result;

    int errors = 0;
    int checks = 0;
    logic [31:0] last_res;

    always #2 clk = ~clk;

    sdiv32x16 i_sdiv32x16 (
        .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .result(result), .wr_en(wr_en),
        .flag_v(flag_v), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
        .div_zero(div_zero)
    );

    // {dividend, divisor, expected packed result, overflow, zero divisor}
    localparam int NV = 14;
    localparam logic [97:0] VEC [NV] = '{
        {32'h00000064, 32'h00000007, 32'h0002000E, 1'b0, 1'b0},
        {32'hFFFFFF9C, 32'h00000007, 32'hFFFEFFF2, 1'b0, 1'b0},
        {32'h00000064, 32'hFFFFFFF9, 32'h0002FFF2, 1'b0, 1'b0},
        {32'hFFFFFF9C, 32'hFFFFFFF9, 32'hFFFE000E, 1'b0, 1'b0},
        {32'h00000005, 32'h00000009, 32'h00050000, 1'b0, 1'b0},
        {32'h00010000, 32'h00000001, 32'h00000000, 1'b1, 1'b0},
        {32'h00008000, 32'h00000001, 32'h00000000, 1'b1, 1'b0},
        {32'hFFFF8000, 32'h00000001, 32'h00008000, 1'b0, 1'b0},
        {32'h00000005, 32'h12340000, 32'h00000000, 1'b0, 1'b1},
        {32'h000003E8, 32'hFFFF000A, 32'h00000064, 1'b0, 1'b0},
        {32'h7FFFFFFF, 32'h00007FFF, 32'h00000000, 1'b1, 1'b0},
        {32'h3FFE8007, 32'h00007FFF, 32'h00057FFE, 1'b0, 1'b0},
        {32'h80000000, 32'h0000FFFF, 32'h00000000, 1'b1, 1'b0},
        {32'hFFFFFFF9, 32'h00000002, 32'hFFFFFFFD, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected latency from the requirement: short path when divisor is zero
    // or the magnitude quotient reaches 2^16.
    function automatic int exp_latency(input logic [31:0] a, input logic [31:0] b);
        longint sa, sb;
        sa = longint'($signed(a));
        sb = longint'($signed(b[15:0]));
        if (sb == 0) return 1;
        if (sa < 0) sa = -sa;
        if (sb < 0) sb = -sb;
        if ((sa / sb) >= 65536) return 1;
        return 17;
    endfunction

    // Issue one request; returns cycles until done and the done-cycle outputs.
    task automatic run_op(input logic [31:0] a, input logic [31:0] b, output int lat);
        @(negedge clk);
        dividend = a;
        divisor  = b;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        chk("R9 busy", {31'd0, busy}, 32'd0);
        chk("R9 done/wr/dz", {29'd0, done, wr_en, div_zero}, 32'd0);
        chk("R9 flags", {28'd0, flag_v, flag_n, flag_z, flag_c}, 32'd0);
        chk("R9 result", result, 32'd0);
        last_res = 32'd0;

        for (int i = 0; i < NV; i++) begin
            logic [31:0] a, b, er;
            logic ev, ez, ok;
            {a, b, er, ev, ez} = VEC[i];
            ok = !ev && !ez;
            run_op(a, b, lat);
            chk("R6 latency", 32'(lat), 32'(exp_latency(a, b)));
            chk("R7 done", {31'd0, done}, 32'd1);
            if (ok) begin
                chk("R1 R2 result", result, er);
                chk("R5 N", {31'd0, flag_n}, {31'd0, er[15]});
                chk("R5 Z", {31'd0, flag_z}, {31'd0, er[15:0] == 16'd0});
                last_res = er;
            end else begin
                chk("R3 R4 result kept", result, last_res);
                chk("R5 NZ cleared", {30'd0, flag_n, flag_z}, 32'd0);
            end
            chk("R3 V", {31'd0, flag_v}, {31'd0, ev});
            chk("R4 div_zero", {31'd0, div_zero}, {31'd0, ez});
            chk("R7 wr_en", {31'd0, wr_en}, {31'd0, ok});
            chk("R5 C", {31'd0, flag_c}, 32'd0);
            @(negedge clk);
            chk("R7 done pulse", {30'd0, done, wr_en}, 32'd0);
        end

        // R6: busy stays high during the step sequence
        @(negedge clk);
        dividend = 32'd100; divisor = 32'd7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R6 busy", {31'd0, busy}, 32'd1);
        // R8: new start while busy is ignored
        @(negedge clk);
        dividend = 32'd5; divisor = 32'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 3;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        chk("R8 latency", 32'(lat), 32'd17);
        chk("R8 result", result, 32'h0002000E);
        chk("R8 no dz", {31'd0, div_zero}, 32'd0);
        begin
            int extra = 0;
            for (int k = 0; k < 25; k++) begin
                @(negedge clk);
                if (done) extra++;
            end
            chk("R8 no extra done", 32'(extra), 32'd0);
        end

        // R9: reset in the middle of a run
        @(negedge clk);
        dividend = 32'd1000; divisor = 32'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9 mid reset busy/done", {30'd0, busy, done}, 32'd0);
        chk("R9 mid reset result", result, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule